// File: doc/BRIEF.md
# Over-Current Pulse-Skip Protection Sequencer

This block sits beside the PWM modulator of a synchronous buck converter and decides, one switching cycle at a time, whether the high-side switch may fire. At every cycle boundary it takes a digitized current-limit flag from the analog front end. A flag seen at a cycle boundary starts an episode. The block suppresses the high-side pulse for that cycle and for a fixed run of following cycles. It then watches a probation window of further cycles. If the flag comes back inside that window, the block sets a shutdown latch. If it does not, normal switching resumes.

The latch holds the high-side drive off. Its fault output is also the request that holds the power-good indication low. Only two things release it: driving the enable input low, or the asynchronous power-on reset. The analog sensing, the threshold setting and the gate drivers are outside the block.

Top module: `ocp_pulse_skip_seq`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released, `hs_inhibit_o` and `fault_o` are both 0.
- R2: When idle, the flag is taken only at a clock edge where `cyc_start_i` and `en_i` are both 1. A high `ilim_i` without a strobe, or with `en_i` low, changes neither output.
- R3: A strobe with `ilim_i` = 1 while idle sets `hs_inhibit_o` from the next clock edge. It stays set through the triggering cycle and through the SKIP_CYCLES (8) cycles that follow. It clears after the edge that samples strobe number SKIP_CYCLES+1 (9) of the episode, counting the trigger as 0.
- R4: The flag is ignored at strobes 1 to SKIP_CYCLES of an episode. It neither extends the skip run nor raises `fault_o`.
- R5: A flag at any strobe from 9 to 16 of the episode (SKIP_CYCLES+1 to SKIP_CYCLES+WATCH_CYCLES) sets `fault_o` and `hs_inhibit_o` from the next clock edge.
- R6: If strobes 9 to 16 all see the flag low, the block is idle again after strobe 16. A flag at strobe 17 then starts a fresh skip episode and does not set a fault.
- R7: Once set, `fault_o` and `hs_inhibit_o` stay at 1 while `en_i` is 1, whatever happens on the strobe and the flag.
- R8: `en_i` low at a clock edge returns the block to idle. Both outputs are 0 after that edge.
- R9: Asserting `rst_ni` while latched clears `fault_o` and `hs_inhibit_o` immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cyc_start_i | input | 1 | One-clock strobe marking the start of a switching cycle |
| ilim_i | input | 1 | Digitized current-limit comparator flag |
| en_i | input | 1 | Converter enable; low clears the latch |
| hs_inhibit_o | output | 1 | Suppress the high-side pulse of the current cycle |
| fault_o | output | 1 | Protection latch set; forces power-good low |

## Verification
The bench builds the block with SKIP_CYCLES = 8 and WATCH_CYCLES = 8, which gives a 4-bit phase counter. Every episode boundary is then a few dozen clocks away. Directed runs place the flag on strobes 8, 9, 16 and 17 of an episode, and on clocks between strobes. The seeded random phase varies strobe density, flag rate and enable drops. It therefore also reaches episodes that are cut short by a disable, and back-to-back episodes that begin right after a clean probation window.

// File: rtl/ocp_seq_pkg.sv
package ocp_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_WATCH = 2'd2,
    ST_FAULT = 2'd3
  } ocp_state_e;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_ONE   = 2'd2,
    CNT_INC   = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/ocp_strobe_qual.sv
module ocp_strobe_qual (
  input  logic cyc_start_i,
  input  logic ilim_i,
  input  logic en_i,
  output logic tick_o,
  output logic hit_o,
  output logic off_o
);

  // the flag only counts when a cycle boundary lands on an enabled clock
  always_comb begin
    tick_o = cyc_start_i & en_i;
    hit_o  = cyc_start_i & en_i & ilim_i;
    off_o  = ~en_i;
  end

endmodule

// File: rtl/ocp_phase_cnt.sv
module ocp_phase_cnt
  import ocp_seq_pkg::*;
#(
  parameter int unsigned SKIP_CYCLES  = 8,
  parameter int unsigned WATCH_CYCLES = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cnt_op_e op_i,
  output logic    skip_done_o,
  output logic    watch_last_o
);

  localparam int unsigned CNT_MAX = (SKIP_CYCLES > WATCH_CYCLES) ? SKIP_CYCLES : WATCH_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        CNT_CLEAR: cnt_q <= '0;
        CNT_ONE:   cnt_q <= CNT_W'(1);
        CNT_INC:   cnt_q <= (cnt_q == CNT_W'(CNT_MAX)) ? cnt_q : cnt_q + CNT_W'(1);
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign skip_done_o  = (cnt_q == CNT_W'(SKIP_CYCLES));
  assign watch_last_o = (cnt_q == CNT_W'(WATCH_CYCLES - 1));

  // R4: the phase counter never runs past the longer window
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX));

  p_clear_takes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_CLEAR) |=> (cnt_q == '0));

endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
  import ocp_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    hit_i,
  input  logic    off_i,
  input  logic    skip_done_i,
  input  logic    watch_last_i,
  output cnt_op_e cnt_op_o,
  output logic    inhibit_o,
  output logic    fault_o
);

  ocp_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cnt_op_o = CNT_HOLD;
    if (off_i) begin
      state_d  = ST_IDLE;
      cnt_op_o = CNT_CLEAR;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_op_o = CNT_CLEAR;
          if (hit_i) state_d = ST_SKIP;
        end
        ST_SKIP: begin
          if (tick_i) begin
            if (!skip_done_i) begin
              cnt_op_o = CNT_INC;
            end else if (hit_i) begin
              state_d  = ST_FAULT;
              cnt_op_o = CNT_CLEAR;
            end else begin
              // first probation cycle already observed clean
              state_d  = ST_WATCH;
              cnt_op_o = CNT_ONE;
            end
          end
        end
        ST_WATCH: begin
          if (tick_i) begin
            if (hit_i) begin
              state_d  = ST_FAULT;
              cnt_op_o = CNT_CLEAR;
            end else if (watch_last_i) begin
              state_d  = ST_IDLE;
              cnt_op_o = CNT_CLEAR;
            end else begin
              cnt_op_o = CNT_INC;
            end
          end
        end
        ST_FAULT: cnt_op_o = CNT_CLEAR;
        default: begin
          state_d  = ST_IDLE;
          cnt_op_o = CNT_CLEAR;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign inhibit_o = (state_q == ST_SKIP) || (state_q == ST_FAULT);
  assign fault_o   = (state_q == ST_FAULT);

  p_fault_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !off_i) |=> fault_o);

  p_disable_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> (!fault_o && !inhibit_o));

  p_fault_needs_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(hit_i));

  p_fault_inhibits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> inhibit_o);

endmodule

// File: rtl/ocp_pulse_skip_seq.sv
module ocp_pulse_skip_seq
  import ocp_seq_pkg::*;
#(
  parameter int unsigned SKIP_CYCLES  = 8,
  parameter int unsigned WATCH_CYCLES = 8   // must be 2 or more
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_start_i,
  input  logic ilim_i,
  input  logic en_i,
  output logic hs_inhibit_o,
  output logic fault_o
);

  logic    tick, hit, off;
  logic    skip_done, watch_last;
  cnt_op_e cnt_op;

  ocp_strobe_qual u_qual (
    .cyc_start_i (cyc_start_i),
    .ilim_i      (ilim_i),
    .en_i        (en_i),
    .tick_o      (tick),
    .hit_o       (hit),
    .off_o       (off)
  );

  ocp_phase_cnt #(
    .SKIP_CYCLES  (SKIP_CYCLES),
    .WATCH_CYCLES (WATCH_CYCLES)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (cnt_op),
    .skip_done_o  (skip_done),
    .watch_last_o (watch_last)
  );

  ocp_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .hit_i        (hit),
    .off_i        (off),
    .skip_done_i  (skip_done),
    .watch_last_i (watch_last),
    .cnt_op_o     (cnt_op),
    .inhibit_o    (hs_inhibit_o),
    .fault_o      (fault_o)
  );

  p_onset_needs_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_inhibit_o) |-> $past(cyc_start_i && ilim_i && en_i));

  p_no_strobe_no_onset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_inhibit_o && !cyc_start_i) |=> !hs_inhibit_o);

  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!hs_inhibit_o && !fault_o));

endmodule

// File: tb/ocp_pulse_skip_seq_tb_top.sv
`timescale 1ns/1ps
module ocp_pulse_skip_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0;
  logic ilim = 1'b0;
  logic en = 1'b0;
  logic hs_inhibit, fault;

  always #2 clk = ~clk;

  ocp_pulse_skip_seq #(.SKIP_CYCLES(8), .WATCH_CYCLES(8)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cyc_start_i  (cyc_start),
    .ilim_i       (ilim),
    .en_i         (en),
    .hs_inhibit_o (hs_inhibit),
    .fault_o      (fault)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference: 0 idle, 1 in episode (m_k strobes since trigger), 2 latched
  int m_state = 0;
  int m_k = 0;

  function automatic void model_step(bit s, bit f, bit e);
    if (!e) begin
      m_state = 0;
    end else if (m_state == 0) begin
      if (s && f) begin m_state = 1; m_k = 0; end
    end else if (m_state == 1) begin
      if (s) begin
        m_k = m_k + 1;
        if (m_k >= 9 && f)  m_state = 2;
        else if (m_k == 16) m_state = 0;
      end
    end
  endfunction

  function automatic bit exp_inh();
    return (m_state == 2) || (m_state == 1 && m_k <= 8);
  endfunction

  function automatic bit exp_flt();
    return m_state == 2;
  endfunction

  task automatic check(string req);
    n_vec++;
    if (hs_inhibit !== exp_inh() || fault !== exp_flt()) begin
      n_bad++;
      $display("FAIL %s: inhibit=%0b fault=%0b expected inhibit=%0b fault=%0b",
               req, hs_inhibit, fault, exp_inh(), exp_flt());
    end
  endtask

  task automatic step(bit s, bit f, bit e, string req);
    cyc_start = s; ilim = f; en = e;
    @(posedge clk);
    model_step(s, f, e);
    @(negedge clk);
    cyc_start = 1'b0; ilim = 1'b0;
    check(req);
  endtask

  // n strobes, each followed by a gap clock carrying a stray flag
  task automatic strobes(int n, bit f, string req);
    for (int i = 0; i < n; i++) begin
      step(1'b1, f, 1'b1, req);
      step(1'b0, 1'b1, 1'b1, req);
    end
  endtask

  task automatic do_reset(string req);
    rst_n = 1'b0;
    m_state = 0; m_k = 0;
    #1;
    check(req);
    @(negedge clk);
    check(req);
    rst_n = 1'b1;
    @(negedge clk);
    check(req);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1 reset state
    do_reset("R1");
    en = 1'b1;
    step(1'b0, 1'b0, 1'b1, "R1");

    // R2 flag between strobes, and strobe+flag while disabled
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b1, "R2");

    // R3 trigger, R4 flags on strobes 1..8 ignored, strobe 9 clean ends skipping
    step(1'b1, 1'b1, 1'b1, "R3");
    strobes(7, 1'b1, "R4");
    step(1'b1, 1'b1, 1'b1, "R4");   // strobe 8
    step(1'b1, 1'b0, 1'b1, "R3");   // strobe 9
    // R6 clean probation then fresh episode at strobe 17
    strobes(7, 1'b0, "R6");         // strobes 10..16
    step(1'b1, 1'b1, 1'b1, "R6");   // strobe 17 -> new episode
    strobes(8, 1'b0, "R3");         // strobes 1..8 of second episode
    // R5 flag on the last probation strobe
    strobes(7, 1'b0, "R5");         // strobes 9..15
    step(1'b1, 1'b1, 1'b1, "R5");   // strobe 16

    // R7 latch holds
    strobes(5, 1'b1, "R7");
    strobes(3, 1'b0, "R7");

    // R8 disable clears, flags ignored while low
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");

    // R5 flag on first probation strobe, then R9 async reset
    step(1'b1, 1'b1, 1'b1, "R5");
    strobes(8, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b1, "R5");   // strobe 9
    step(1'b0, 1'b0, 1'b1, "R9");
    do_reset("R9");

    // seeded random mix
    for (int i = 0; i < 6000; i++) begin
      bit s, f, e;
      string t;
      s = ($urandom % 3) == 0;
      f = ($urandom % ((i / 1500) + 2)) == 0;
      e = ($urandom % 200) != 0;
      case (m_state)
        0:       t = "R2";
        1:       t = (m_k < 8) ? "R4" : "R5";
        default: t = "R7";
      endcase
      if (!e) t = "R8";
      step(s, f, e, t);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule